// File: doc/BRIEF.md
# Pipeline Hazard and Operand Bypass Control

This block is the hazard-control logic for a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back). It has no state of its own. Each cycle it compares the source register numbers of the instructions in decode and execute with the destination register numbers of the older instructions further down the pipe. From that comparison it chooses where each ALU operand comes from, and it decides whether the front of the pipe must pause for a load.

Register reads happen only in decode and register writes only in write-back, so the only dependence that needs handling is a read that follows a write. A result still in flight is routed back to the ALU input from the execute/memory pipeline register or from the memory/write-back register. A loaded value is not available in time for the very next instruction. In that case the block holds the PC and the fetch/decode register for one cycle and turns the execute-stage slot into a no-op. The register file is assumed to write in the first half of a cycle and read in the second half. A producer that is in write-back while its reader is in decode therefore needs no help, and an instruction three places behind its producer reads the value from the register file.

Top module: `hazard_unit`

## Requirements
- R1: An ALU operand select equals 2'b10 (take the execute/memory register result) when that stage writes a register, its destination is not register 0, and the destination equals the operand's execute-stage source.
- R2: An operand select equals 2'b01 (take the memory/write-back register result) when that stage writes a nonzero destination equal to the source and the condition of R1 does not hold for that source.
- R3: When both later stages write the same nonzero register that an operand reads, the execute/memory result wins and the select is 2'b10.
- R4: The select is 2'b00 (register file value) when no enabled write matches. A source or destination of register 0 never produces a bypass.
- R5: The two operand selects are independent: fwd_a follows ex_rs1 only and fwd_b follows ex_rs2 only, so each operand may use a different path in the same cycle.
- R6: When the execute-stage instruction is a load that writes a nonzero register equal to either decode-stage source, stall is 1 and bubble is 1 in that cycle.
- R7: No stall is raised for a matching producer in execute that is not a load, for a load whose write enable is low, or for a load whose destination is register 0.
- R8: A matching writer in the memory or write-back stage never raises a stall, because the register file writes before it reads and bypassing covers the memory stage.
- R9: bubble always equals stall, and neither operand select ever takes the unused code 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | REG_AW | First source register of the instruction in decode |
| id_rs2 | input | REG_AW | Second source register of the instruction in decode |
| ex_rs1 | input | REG_AW | First source register of the instruction in execute |
| ex_rs2 | input | REG_AW | Second source register of the instruction in execute |
| ex_rd | input | REG_AW | Destination register of the instruction in execute |
| ex_wen | input | 1 | Instruction in execute writes a register |
| ex_is_load | input | 1 | Instruction in execute is a load |
| mem_rd | input | REG_AW | Destination register held in the execute/memory register |
| mem_wen | input | 1 | Instruction in memory stage writes a register |
| wb_rd | input | REG_AW | Destination register held in the memory/write-back register |
| wb_wen | input | 1 | Instruction in write-back writes a register |
| fwd_a | output | 2 | Operand A source: 00 register file, 01 memory/write-back, 10 execute/memory |
| fwd_b | output | 2 | Operand B source, same encoding as fwd_a |
| stall | output | 1 | Hold the PC and the fetch/decode register this cycle |
| bubble | output | 1 | Clear the control fields entering the execute stage to a no-op |

## Verification
The bypass selects are tried with a single match in one stage, with matches in both stages at once, and with matches whose write enable is low or whose register is 0. Together these separate correct priority, enable gating and zero-register exclusion from one another. Operand A and operand B are given different producers in the same cycle, which exposes any crossed wiring between the two operands. The interlock is tried with a load and with a non-load producer in execute, and with producers parked in the memory and write-back stages. This shows that only a load in execute can pause the pipe. A long pseudorandom sweep over a four-register space then covers the mixed cases.

// File: rtl/hazard_pkg.sv
// Shared definitions for the pipeline hazard unit.
// Assumes a two-operand ALU in the execute stage.
package hazard_pkg;

    // Operand source select; the code values are decoded by the ALU input muxes.
    typedef enum logic [1:0] {
        BYP_RF  = 2'b00,
        BYP_WB  = 2'b01,
        BYP_MEM = 2'b10
    } byp_sel_e;

    // Number of register operands read by one instruction.
    localparam int unsigned NUM_SRC = 2;

endpackage

// File: rtl/hazard_bypass_sel.sv
// Chooses the source of one ALU operand in the execute stage.
// Assumes a write to register 0 is discarded by the register file, so such
// a write is never a valid bypass source. The execute/memory result is newer
// than the memory/write-back result and therefore takes precedence.
module hazard_bypass_sel
    import hazard_pkg::*;
#(
    parameter int unsigned REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_wen,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_wen,
    output byp_sel_e          sel
);

    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic mem_hit;
    logic wb_hit;

    // Match each later stage's pending write against this operand.
    always_comb begin
        mem_hit = mem_wen && (mem_rd != ZERO_REG) && (mem_rd == src);
        wb_hit  = wb_wen  && (wb_rd  != ZERO_REG) && (wb_rd  == src);
    end

    // Pick the newest matching value, else the register file.
    always_comb begin
        if (mem_hit) begin
            sel = BYP_MEM;
        end else if (wb_hit) begin
            sel = BYP_WB;
        end else begin
            sel = BYP_RF;
        end
    end

endmodule

// File: rtl/hazard_load_interlock.sv
// Detects a load in execute whose result is needed by the instruction in decode.
// Assumes load data is available one stage after execute, so exactly one
// bubble makes the memory/write-back bypass sufficient.
module hazard_load_interlock
    import hazard_pkg::*;
#(
    parameter int unsigned REG_AW = 5
) (
    input  logic [NUM_SRC-1:0][REG_AW-1:0] id_src,
    input  logic [REG_AW-1:0]              ex_rd,
    input  logic                           ex_wen,
    input  logic                           ex_is_load,
    output logic                           hold
);

    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic               load_pending;
    logic [NUM_SRC-1:0] src_match;

    // Qualify the execute-stage instruction as a real load producer.
    always_comb begin
        load_pending = ex_is_load && ex_wen && (ex_rd != ZERO_REG);
    end

    // Compare each decode-stage source with the load destination.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        always_comb begin
            src_match[i] = (id_src[i] == ex_rd);
        end
    end

    // Request a one-cycle pause when any source depends on the load.
    always_comb begin
        hold = load_pending && (|src_match);
    end

endmodule

// File: rtl/hazard_unit.sv
// Hazard control for a five-stage in-order pipeline: operand bypass selects
// for the ALU and the load-use interlock.
// Assumes writes happen only in write-back, reads only in decode, and the
// register file writes in the first half-cycle and reads in the second.
module hazard_unit
    import hazard_pkg::*;
#(
    parameter int unsigned REG_AW = 5
) (
    input  logic [REG_AW-1:0] id_rs1,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic [REG_AW-1:0] ex_rs1,
    input  logic [REG_AW-1:0] ex_rs2,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_wen,
    input  logic              ex_is_load,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_wen,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_wen,
    output logic [1:0]        fwd_a,
    output logic [1:0]        fwd_b,
    output logic              stall,
    output logic              bubble
);

    logic [NUM_SRC-1:0][REG_AW-1:0] id_src;
    logic [NUM_SRC-1:0][REG_AW-1:0] ex_src;
    byp_sel_e                       sel [NUM_SRC];
    logic                           hold;

    // Gather operand register numbers into indexed form.
    always_comb begin
        id_src[0] = id_rs1;
        id_src[1] = id_rs2;
        ex_src[0] = ex_rs1;
        ex_src[1] = ex_rs2;
    end

    // One bypass selector per ALU operand.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_byp
        hazard_bypass_sel #(
            .REG_AW (REG_AW)
        ) u_sel (
            .src     (ex_src[i]),
            .mem_rd  (mem_rd),
            .mem_wen (mem_wen),
            .wb_rd   (wb_rd),
            .wb_wen  (wb_wen),
            .sel     (sel[i])
        );
    end

    hazard_load_interlock #(
        .REG_AW (REG_AW)
    ) u_ilk (
        .id_src     (id_src),
        .ex_rd      (ex_rd),
        .ex_wen     (ex_wen),
        .ex_is_load (ex_is_load),
        .hold       (hold)
    );

    // Drive operand selects and the pause controls.
    always_comb begin
        fwd_a  = sel[0];
        fwd_b  = sel[1];
        stall  = hold;
        bubble = hold;
    end

endmodule

// File: rtl/hazard_unit_chk.sv
// Property checker for hazard_unit; the block is combinational, so the
// checks are immediate assertions re-evaluated whenever a port changes.
module hazard_unit_chk #(
    parameter int unsigned REG_AW = 5
) (
    input logic [REG_AW-1:0] id_rs1,
    input logic [REG_AW-1:0] id_rs2,
    input logic [REG_AW-1:0] ex_rs1,
    input logic [REG_AW-1:0] ex_rs2,
    input logic [REG_AW-1:0] ex_rd,
    input logic              ex_wen,
    input logic              ex_is_load,
    input logic [REG_AW-1:0] mem_rd,
    input logic              mem_wen,
    input logic [REG_AW-1:0] wb_rd,
    input logic              wb_wen,
    input logic [1:0]        fwd_a,
    input logic [1:0]        fwd_b,
    input logic              stall,
    input logic              bubble
);

    // Check port relations whenever any of them moves.
    always_comb begin
        assert_mem_sel_source_R1: assert (fwd_a != 2'b10 ||
            (mem_wen && (mem_rd != '0) && (mem_rd == ex_rs1)))
            else $error("R1 violated");
        assert_wb_sel_source_R2: assert (fwd_b != 2'b01 ||
            (wb_wen && (wb_rd != '0) && (wb_rd == ex_rs2)))
            else $error("R2 violated");
        assert_mem_wins_R3: assert (!(mem_wen && (mem_rd != '0) && (mem_rd == ex_rs1)) ||
            fwd_a == 2'b10)
            else $error("R3 violated");
        assert_zero_reg_R4: assert ((ex_rs1 != '0 || fwd_a == 2'b00) &&
            (ex_rs2 != '0 || fwd_b == 2'b00))
            else $error("R4 violated");
        assert_load_use_R6: assert (!(ex_is_load && ex_wen && (ex_rd != '0) &&
            ((ex_rd == id_rs1) || (ex_rd == id_rs2))) || stall)
            else $error("R6 violated");
        assert_stall_cause_R7: assert (!stall || (ex_is_load && ex_wen && (ex_rd != '0)))
            else $error("R7 violated");
        assert_bubble_stall_R9: assert (bubble == stall && fwd_a != 2'b11 && fwd_b != 2'b11)
            else $error("R9 violated");
    end

endmodule

bind hazard_unit hazard_unit_chk #(.REG_AW(REG_AW)) u_chk (
    .id_rs1     (id_rs1),
    .id_rs2     (id_rs2),
    .ex_rs1     (ex_rs1),
    .ex_rs2     (ex_rs2),
    .ex_rd      (ex_rd),
    .ex_wen     (ex_wen),
    .ex_is_load (ex_is_load),
    .mem_rd     (mem_rd),
    .mem_wen    (mem_wen),
    .wb_rd      (wb_rd),
    .wb_wen     (wb_wen),
    .fwd_a      (fwd_a),
    .fwd_b      (fwd_b),
    .stall      (stall),
    .bubble     (bubble)
);

// File: tb/test_hazard_unit.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected outputs, the monitor compares
// them half a cycle after each stimulus.
module test_hazard_unit;

    localparam int unsigned AW = 5;

    typedef struct packed {
        logic [1:0] a;
        logic [1:0] b;
        logic       st;
    } exp_t;

    logic clk = 1'b0;
    logic [AW-1:0] id_rs1 = '0, id_rs2 = '0, ex_rs1 = '0, ex_rs2 = '0, ex_rd = '0;
    logic [AW-1:0] mem_rd = '0, wb_rd = '0;
    logic ex_wen = 1'b0, ex_is_load = 1'b0, mem_wen = 1'b0, wb_wen = 1'b0;
    logic [1:0] fwd_a, fwd_b;
    logic stall, bubble;

    exp_t  exp_q[$];
    string tag_q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    hazard_unit #(.REG_AW(AW)) i_hazard_unit (
        .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
        .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_is_load(ex_is_load),
        .mem_rd(mem_rd), .mem_wen(mem_wen), .wb_rd(wb_rd), .wb_wen(wb_wen),
        .fwd_a(fwd_a), .fwd_b(fwd_b), .stall(stall), .bubble(bubble)
    );

    // Expected operand source, written from R1 to R4.
    function automatic logic [1:0] want_sel(input logic [AW-1:0] s,
                                            input logic [AW-1:0] mrd, input logic mw,
                                            input logic [AW-1:0] wrd, input logic ww);
        if (s == 0)                 return 2'b00;
        if (mw && mrd == s)         return 2'b10;
        if (ww && wrd == s)         return 2'b01;
        return 2'b00;
    endfunction

    task automatic apply(input string tag,
                         input logic [AW-1:0] i1, input logic [AW-1:0] i2,
                         input logic [AW-1:0] e1, input logic [AW-1:0] e2,
                         input logic [AW-1:0] erd, input logic ew, input logic eld,
                         input logic [AW-1:0] mrd, input logic mw,
                         input logic [AW-1:0] wrd, input logic ww);
        exp_t e;
        @(posedge clk);
        #1;
        id_rs1 = i1; id_rs2 = i2; ex_rs1 = e1; ex_rs2 = e2;
        ex_rd = erd; ex_wen = ew; ex_is_load = eld;
        mem_rd = mrd; mem_wen = mw; wb_rd = wrd; wb_wen = ww;
        e.a  = want_sel(e1, mrd, mw, wrd, ww);
        e.b  = want_sel(e2, mrd, mw, wrd, ww);
        e.st = eld && ew && (erd != 0) && (erd == i1 || erd == i2);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare one item per cycle, away from the driving edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (fwd_a !== e.a || fwd_b !== e.b || stall !== e.st || bubble !== e.st) begin
                fails++;
                $display("FAIL %s: got a=%b b=%b stall=%b bubble=%b, expected a=%b b=%b stall=%b bubble=%b",
                         t, fwd_a, fwd_b, stall, bubble, e.a, e.b, e.st, e.st);
            end
        end
    end

    initial begin
        //     tag   id1 id2 ex1 ex2 erd ew eld mrd mw wrd ww
        apply("R4",  0,  0,  0,  0,  0,  0, 0,  0,  0, 0,  0);  // idle state
        apply("R1",  0,  0,  3,  4,  0,  0, 0,  3,  1, 0,  0);
        apply("R5",  0,  0,  6,  3,  0,  0, 0,  3,  1, 0,  0);  // B only
        apply("R2",  0,  0,  9,  4,  0,  0, 0,  0,  0, 9,  1);
        apply("R3",  0,  0,  5,  2,  0,  0, 0,  5,  1, 5,  1);  // both stages match
        apply("R2",  0,  0,  5,  2,  0,  0, 0,  5,  0, 5,  1);  // mem write disabled
        apply("R4",  0,  0,  0,  0,  0,  0, 0,  0,  1, 0,  1);  // register 0
        apply("R4",  0,  0,  7,  8,  0,  0, 0,  7,  0, 8,  0);  // enables low
        apply("R5",  0,  0, 10, 11,  0,  0, 0, 10,  1, 11, 1);  // A mem, B wb
        apply("R5",  0,  0, 12, 12,  0,  0, 0,  0,  0, 12, 1);  // same src both
        apply("R6",  7,  1,  0,  0,  7,  1, 1,  0,  0, 0,  0);
        apply("R6",  2,  7,  0,  0,  7,  1, 1,  0,  0, 0,  0);
        apply("R7",  7,  7,  0,  0,  7,  1, 0,  0,  0, 0,  0);  // not a load
        apply("R7",  0,  0,  0,  0,  0,  1, 1,  0,  0, 0,  0);  // load to r0
        apply("R7",  7,  3,  0,  0,  7,  0, 1,  0,  0, 0,  0);  // load, wen low
        apply("R8", 13, 14,  1,  2,  3,  1, 1, 13,  1, 14, 1);  // later writers
        apply("R9", 20, 21, 20, 21, 20,  1, 1, 20,  1, 21, 1);  // stall with bypass
        for (int n = 0; n < 400; n++) begin
            apply("R9",
                  AW'($urandom_range(0, 3)), AW'($urandom_range(0, 3)),
                  AW'($urandom_range(0, 3)), AW'($urandom_range(0, 3)),
                  AW'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  AW'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                  AW'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule